// File: doc/BRIEF.md
# Pausable Nibble Display with Squarer

The block divides its clock with a wide free-running up counter and shows the counter's upper four bits on an 8-bit lamp bus. A select input chooses what the lamps show: either those four bits padded with zeros to eight bits, or the four-bit value multiplied by itself. A hold input stops the counter, so the display freezes on whichever view is selected.

The three control inputs may come from buttons or other logic in a different timing domain. Each one goes through a two-stage synchronizer before use. Reset is synchronous and active low, and it overrides the hold input. The lamp bus is registered, so a new counter value or a new select shows up one clock later. The counter width is a parameter, which lets a bench use a short counter.

Top module: `nibble_lamp`

## Requirements
- R1: While not held and not in reset, the counter advances by exactly one on every rising clock edge.
- R2: The counter rolls over from all ones to zero and gives no other sign that it did so.
- R3: With the synchronized select low, the lamps show {4'b0000, top four counter bits} one clock after the counter value they reflect.
- R4: With the synchronized select high, the lamps show the top four counter bits squared as an unsigned 8-bit value, one clock after the counter value.
- R5: While the synchronized hold input is high, the counter keeps its value and the lamps stay constant in either view.
- R6: While the synchronized reset is low, the counter and the lamps go to zero, even when hold is high.
- R7: A change on select, hold or reset reaches the lamp register on the third rising edge after the change is first sampled, and not earlier.
- R8: The squared view covers the full range; a nibble of 15 shows as 225.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low, synchronized inside |
| pause | input | 1 | Counter hold, active high, synchronized inside |
| toggle | input | 1 | View select: 0 shows the padded nibble, 1 shows its square |
| led | output | 8 | Registered lamp bus |

## Verification
The assertions observe the signals after the synchronizers. They assume nothing about the raw inputs, but they only judge cycles in which the synchronized reset is high, plus the reset response itself. Those properties rest on hold and select being stable for at least the two synchronizer stages before they matter. The bench changes its inputs only on falling edges and holds each setting for many cycles, so every input reaches the lamp logic cleanly. The short counter used in the bench lets every nibble value, including 15 and the rollover, appear within a few hundred cycles.

// File: rtl/nibble_lamp_pkg.sv
// Shared constants for the nibble lamp block.
// Assumes the displayed value is one nibble and the lamp bus is twice its width.
package nibble_lamp_pkg;
    localparam int NIB_W       = 4;
    localparam int LAMP_W      = 2 * NIB_W;
    localparam int SYNC_STAGES = 2;
    typedef logic [LAMP_W-1:0] lamp_t;
endpackage

// File: rtl/nl_sync.sv
// Multi-bit, multi-stage synchronizer for independent level signals.
// Assumes each bit is a slow level, so bits need not arrive together.
// It has no reset, so a reset input can pass through it as well.
module nl_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    // First stage samples the asynchronous inputs.
    always_ff @(posedge clk) begin
        pipe[0] <= d;
    end

    genvar i;
    generate
        for (i = 1; i < STAGES; i++) begin : g_stage
            // Each later stage re-times the stage before it.
            always_ff @(posedge clk) begin
                pipe[i] <= pipe[i-1];
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/nl_divider.sv
// Free-running up counter with a hold input.
// Assumes synchronous active-low reset; reset wins over hold. Rolls over silently.
module nl_divider #(
    parameter int W = 29
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    output logic [W-1:0] count
);
    // Clear on reset, freeze on hold, otherwise advance by one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (!hold)
            count <= count + W'(1);
    end
endmodule

// File: rtl/nl_square.sv
// Combinational unsigned squarer built from shifted partial products.
// Assumes an N-bit unsigned operand; the result is 2N bits and never overflows.
module nl_square #(
    parameter int N = 4
) (
    input  logic [N-1:0]   a,
    output logic [2*N-1:0] p
);
    localparam int PW = 2 * N;

    // Sum one shifted copy of the operand for each set bit.
    always_comb begin
        p = '0;
        for (int i = 0; i < N; i++) begin
            if (a[i])
                p = p + (PW'(a) << i);
        end
    end
endmodule

// File: rtl/nl_display.sv
// Registered 2-to-1 selector for the lamp bus.
// Assumes sel is already synchronized; select low gives the zero-padded nibble.
module nl_display
    import nibble_lamp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic [NIB_W-1:0] nib,
    input  lamp_t            sq,
    output lamp_t            lamp
);
    lamp_t next_lamp;

    // Choose between the padded nibble and its square.
    always_comb begin
        next_lamp = sel ? sq : {{(LAMP_W-NIB_W){1'b0}}, nib};
    end

    // Register the chosen value; reset clears the lamps.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lamp <= '0;
        else
            lamp <= next_lamp;
    end
endmodule

// File: rtl/nibble_lamp.sv
// Top level: synchronizes the controls, runs the divider, squares its top nibble
// and drives the registered lamp bus.
// Assumes CNT_W >= NIB_W. Reset is synchronous and active low after synchronization.
module nibble_lamp
    import nibble_lamp_pkg::*;
#(
    parameter int CNT_W = 29
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pause,
    input  logic       toggle,
    output logic [7:0] led
);
    localparam int TOP = CNT_W - 1;

    logic [2:0]       ctl_s;
    logic             rst_s;
    logic             pause_s;
    logic             toggle_s;
    logic [TOP:0]     cnt;
    logic [NIB_W-1:0] nib;
    lamp_t            sq;
    lamp_t            lamp;

    nl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   ({rst_n, pause, toggle}),
        .q   (ctl_s)
    );

    assign rst_s    = ctl_s[2];
    assign pause_s  = ctl_s[1];
    assign toggle_s = ctl_s[0];

    nl_divider #(.W(CNT_W)) u_div (
        .clk   (clk),
        .rst_n (rst_s),
        .hold  (pause_s),
        .count (cnt)
    );

    assign nib = cnt[TOP -: NIB_W];

    nl_square #(.N(NIB_W)) u_sq (
        .a (nib),
        .p (sq)
    );

    nl_display u_disp (
        .clk   (clk),
        .rst_n (rst_s),
        .sel   (toggle_s),
        .nib   (nib),
        .sq    (sq),
        .lamp  (lamp)
    );

    assign led = lamp;
endmodule

// File: rtl/nl_checker.sv
// Property checker for nibble_lamp, attached with bind.
// Observes the synchronized controls, the counter and the lamp bus.
module nl_checker #(
    parameter int CNT_W = 29
) (
    input logic             clk,
    input logic             rst_s,
    input logic             pause_s,
    input logic             toggle_s,
    input logic [CNT_W-1:0] cnt,
    input logic [7:0]       led
);
    logic [3:0] nib;
    logic [7:0] nib_sq;
    assign nib    = cnt[CNT_W-1 -: 4];
    assign nib_sq = 8'(nib) * 8'(nib);

    // R1
    advance_chk: assert property (@(posedge clk) disable iff (!rst_s)
        !pause_s |=> cnt == $past(cnt) + CNT_W'(1));

    // R2
    rollover_chk: assert property (@(posedge clk) disable iff (!rst_s)
        (!pause_s && (&cnt)) |=> cnt == '0);

    // R3
    padded_view_chk: assert property (@(posedge clk) disable iff (!rst_s)
        !toggle_s |=> led == {4'b0000, $past(nib)});

    // R4
    square_view_chk: assert property (@(posedge clk) disable iff (!rst_s)
        toggle_s |=> led == $past(nib_sq));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
        pause_s |=> $stable(cnt));

    // R6
    reset_clear_chk: assert property (@(posedge clk)
        !rst_s |=> (cnt == '0 && led == 8'd0));
endmodule

bind nibble_lamp nl_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_s    (rst_s),
    .pause_s  (pause_s),
    .toggle_s (toggle_s),
    .cnt      (cnt),
    .led      (led)
);

// File: tb/nibble_lamp_test.sv
// Scoreboard bench: a reference model pushes the expected lamp value each cycle,
// a monitor pops and compares it; directed tasks add boundary checks.
module nibble_lamp_test;
    localparam int CNT_W = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pause = 1'b0;
    logic       toggle = 1'b0;
    logic [7:0] led;

    int checks = 0;
    int fails  = 0;
    bit armed  = 1'b0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    nibble_lamp #(.CNT_W(CNT_W)) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .pause  (pause),
        .toggle (toggle),
        .led    (led)
    );

    // Reference model written from the requirements (R1..R7).
    logic             m_r1 = 1'b0, m_r2 = 1'b0, m_p1 = 1'b0, m_p2 = 1'b0, m_t1 = 1'b0, m_t2 = 1'b0;
    logic [CNT_W-1:0] m_cnt = '0;
    logic [7:0]       m_led = '0;
    logic [7:0]       exp_q[$];
    string            req_q[$];

    function automatic logic [3:0] top_nib(logic [CNT_W-1:0] c);
        return c[CNT_W-1 -: 4];
    endfunction

    always @(posedge clk) begin
        string tag;
        if (!m_r2)       tag = "R6";
        else if (m_p2)   tag = "R5";
        else if (m_t2)   tag = "R4";
        else             tag = "R3";
        if (!m_r2) begin
            m_cnt = '0;
            m_led = 8'd0;
        end else begin
            m_led = m_t2 ? 8'(top_nib(m_cnt)) * 8'(top_nib(m_cnt)) : {4'b0, top_nib(m_cnt)};
            if (!m_p2) m_cnt = m_cnt + 1'b1;
        end
        m_r2 = m_r1; m_r1 = rst_n;
        m_p2 = m_p1; m_p1 = pause;
        m_t2 = m_t1; m_t1 = toggle;
        #1;
        exp_q.push_back(m_led);
        req_q.push_back(tag);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: led actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: pop one expected item per cycle and compare away from the edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [7:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            if (armed) check(led == e, r, led, e);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        int guard;
        bit seen;
        logic [7:0] held;
        step(6);
        armed = 1'b1;
        // R6: lamps clear while reset is held.
        check(led == 8'd0, "R6", led, 0);
        rst_n = 1'b1;
        step(3);
        // R3, R1, R2: padded view over a full count period, including rollover.
        seen = 1'b0;
        guard = 0;
        while (led != 8'd15 && guard < 400) begin step(1); guard++; end
        check(led == 8'd15, "R3", led, 15);
        while (led == 8'd15 && guard < 400) begin step(1); guard++; end
        check(led == 8'd0, "R2", led, 0);
        // R7: freeze on a nibble >= 2, flip select, watch latency.
        while (led < 8'd2 && guard < 800) begin step(1); guard++; end
        pause = 1'b1;
        step(5);
        held = led;
        toggle = 1'b1;
        step(2);
        check(led == held, "R7", led, held);
        step(1);
        check(led == held * held, "R7", led, held * held);
        // R5: lamps stay constant while held.
        held = led;
        for (int i = 0; i < 20; i++) begin
            step(1);
            check(led == held, "R5", led, held);
        end
        // R8: squared view reaches 225.
        pause = 1'b0;
        guard = 0;
        while (led != 8'd225 && guard < 400) begin step(1); guard++; end
        check(led == 8'd225, "R8", led, 225);
        step(150);
        // R6: reset wins over hold.
        pause = 1'b1;
        rst_n = 1'b0;
        step(4);
        check(led == 8'd0, "R6", led, 0);
        rst_n = 1'b1;
        pause = 1'b0;
        toggle = 1'b0;
        step(200);
        toggle = 1'b1;
        step(100);
        finish_run();
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule